// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM With Byte Writes

This block is a synchronous static memory holding 18-bit words, each split into two 9-bit byte lanes. Address, write data and every control input are captured on the rising clock edge. The read path is flow-through: it has no output pipeline register, so the word at the captured address reaches the output during the same cycle in which that address was captured. A write is self-timed. It is launched from the captured controls and takes its data from the captured data-in register, so a read of the same word in the following cycle returns the new value.

A write can be requested two ways. A global write stores every lane and ignores the byte controls. A byte-write enable, qualified by a per-lane enable for each lane, stores only the selected lanes. Three chip selects must all be true for any access, which lets several instances share an address space. The output drive also needs the asynchronous output enable and a captured read. A snooze input stops all accesses and turns the output off, and the array keeps its contents. The bidirectional pad is split into a data-in bus, a data-out bus and a drive-enable.

Top module: `ft_sram`

## Requirements
- R1: Address, data-in and all control inputs take effect only at a rising clock edge. Changing the address between edges does not change the data on the output.
- R2: With gwN low, both lanes are written whatever the values of bweN and laneWeN.
- R3: With gwN high and bweN low, lane i is written exactly when laneWeN[i] is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9. Any subset of lanes, the empty one included, may be written. Lanes that are not written keep their contents.
- R4: A cycle with gwN and bweN both high is a read and leaves the array unchanged.
- R5: The write data is the data-in value captured at the write edge. A read captured at the very next edge returns the new word.
- R6: Read data for an address captured at edge k is on dataOut after edge k and before edge k+1.
- R7: An access happens only when selLowN is low, selHighA is high and selHighB is high at the edge. Under any other combination the array is not written and the output is not driven.
- R8: driveEn is high only when the last edge captured a selected read and oeN is low. oeN acts without a clock. dataOut is zero whenever driveEn is low.
- R9: A cycle captured with gwN low or bweN low is a write cycle, and driveEn stays low during it, even when no lane is selected.
- R10: While snooze is captured high, reads and writes are ignored and driveEn is low. The array contents are kept.
- R11: During and right after reset, driveEn and dataOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset of control state, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | 18 | Write data |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| laneWeN | input | 2 | Per-lane write enables, active low |
| selLowN | input | 1 | Chip select, active low |
| selHighA | input | 1 | Chip select, active high |
| selHighB | input | 1 | Chip select, active high |
| snooze | input | 1 | Low-power standby request |
| oeN | input | 1 | Asynchronous output enable, active low |
| dataOut | output | 18 | Read data, zero when not driven |
| driveEn | output | 1 | Output drive-enable |

## Verification
The bench goes after the points where the two write paths meet. If global write did not override the byte controls, the test with gwN low and every lane disabled would find the old word still stored. If a lane's enable were steered to the wrong bit range, the sweep over all four lane subsets would see the wrong half change. Each of the seven non-selecting chip-select patterns is tried as a write. A decode that tested only one select would store data there and show it on the following read. The bench also covers snooze, a write cycle that selects no lanes, and an address change between edges. These would expose a block that drives the output on a write, stores data while snoozing, or reads from the live address instead of the captured one.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;
  localparam int LANES = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic [LANES-1:0] wrLane;
    logic             rdOn;
  } strobe_t;
endpackage

// File: rtl/ft_sram_ctrl.sv
module ft_sram_ctrl
  import ft_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] laneWeN,
  input  logic             selLowN,
  input  logic             selHighA,
  input  logic             selHighB,
  input  logic             snooze,
  input  logic             oeN,
  output strobe_t          stb,
  output logic             driveEn
);
  logic             chipSel;
  logic             wrIntent;
  logic [LANES-1:0] laneSel;
  logic [LANES-1:0] laneReg;
  logic             wrReg;
  logic             rdReg;

  assign chipSel  = !selLowN && selHighA && selHighB && !snooze;
  assign wrIntent = !gwN || !bweN;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneSel[g] = !gwN || (!bweN && !laneWeN[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laneReg <= '0;
      wrReg   <= 1'b0;
      rdReg   <= 1'b0;
    end else begin
      laneReg <= chipSel ? laneSel : '0;
      wrReg   <= chipSel && wrIntent;
      rdReg   <= chipSel && !wrIntent;
    end
  end

  always_comb begin
    stb.wrLane = wrReg ? laneReg : '0;
    stb.rdOn   = rdReg;
  end

  assign driveEn = rdReg && !oeN;
endmodule

// File: rtl/ft_sram_data.sv
module ft_sram_data
  import ft_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  input  strobe_t           stb,
  input  logic              driveEn,
  output logic [WORD_W-1:0] dataOut
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] dinReg;
  logic [WORD_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (stb.wrLane[i]) mem[addrReg][i*LANE_W +: LANE_W] <= dinReg[i*LANE_W +: LANE_W];
    end
    addrReg <= addr;
    dinReg  <= dataIn;
  end

  assign rdWord  = mem[addrReg];
  assign dataOut = driveEn ? rdWord : '0;
endmodule

// File: rtl/ft_sram.sv
module ft_sram
  import ft_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [17:0]       dataIn,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [1:0]        laneWeN,
  input  logic              selLowN,
  input  logic              selHighA,
  input  logic              selHighB,
  input  logic              snooze,
  input  logic              oeN,
  output logic [17:0]       dataOut,
  output logic              driveEn
);
  strobe_t stb;

  ft_sram_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .gwN(gwN), .bweN(bweN), .laneWeN(laneWeN),
    .selLowN(selLowN), .selHighA(selHighA), .selHighB(selHighB),
    .snooze(snooze), .oeN(oeN), .stb(stb), .driveEn(driveEn)
  );

  ft_sram_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .addr(addr), .dataIn(dataIn), .stb(stb),
    .driveEn(driveEn), .dataOut(dataOut)
  );
endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gwN,
  input logic        bweN,
  input logic        selLowN,
  input logic        selHighA,
  input logic        selHighB,
  input logic        snooze,
  input logic        oeN,
  input logic [17:0] dataOut,
  input logic        driveEn
);
  a_r7_no_drive_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(selLowN || !selHighA || !selHighB) |-> !driveEn);

  a_r8_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |-> !driveEn);

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !driveEn |-> (dataOut == 18'd0));

  a_r9_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!gwN || !bweN) |-> !driveEn);

  a_r10_snooze_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snooze) |-> !driveEn);
endmodule

bind ft_sram ft_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gwN(gwN), .bweN(bweN), .selLowN(selLowN),
  .selHighA(selHighA), .selHighB(selHighB), .snooze(snooze), .oeN(oeN),
  .dataOut(dataOut), .driveEn(driveEn)
);

// File: tb/ft_sram_bench.sv
`timescale 1ns/1ps
module ft_sram_bench;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0] dataIn = '0;
  logic gwN = 1'b1, bweN = 1'b1;
  logic [1:0] laneWeN = 2'b11;
  logic selLowN = 1'b0, selHighA = 1'b1, selHighB = 1'b1;
  logic snooze = 1'b0, oeN = 1'b0;
  logic [17:0] dataOut;
  logic driveEn;

  logic [17:0] model [DEPTH];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ft_sram #(.DEPTH(DEPTH)) u_ft_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dataIn(dataIn), .gwN(gwN),
    .bweN(bweN), .laneWeN(laneWeN), .selLowN(selLowN), .selHighA(selHighA),
    .selHighB(selHighB), .snooze(snooze), .oeN(oeN), .dataOut(dataOut),
    .driveEn(driveEn)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic cyc(input string req, input logic [AW-1:0] a, input logic [17:0] d,
                     input logic g, input logic b, input logic [1:0] lw,
                     input logic [2:0] sel, input logic snz, input logic oe);
    logic selected, expDrive;
    logic [17:0] expOut;
    @(negedge clk);
    addr = a; dataIn = d; gwN = g; bweN = b; laneWeN = lw;
    selLowN = sel[0]; selHighA = sel[1]; selHighB = sel[2];
    snooze = snz; oeN = oe;
    @(posedge clk);
    #1;
    selected = !sel[0] && sel[1] && sel[2] && !snz;
    expDrive = selected && g && b && !oe;
    expOut = expDrive ? model[a] : 18'd0;
    check({req, " drive"}, {17'd0, driveEn}, {17'd0, expDrive});
    check({req, " data"}, dataOut, expOut);
    if (selected) begin
      for (int i = 0; i < 2; i++) begin
        if (!g || (!b && !lw[i])) model[a][i*9 +: 9] = d[i*9 +: 9];
      end
    end
  endtask

  function automatic logic [17:0] pat(input int a, input int k);
    return 18'((a * 1237 + k * 4099 + 17) ^ (k * 18'h2A5A5));
  endfunction

  localparam logic [2:0] SEL_ON = 3'b110;

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 18'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset drive", {17'd0, driveEn}, 18'd0);
    check("R11 reset data", dataOut, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: global write fill, byte controls set to a blocking pattern
    for (int a = 0; a < DEPTH; a++) cyc("R2 R9 fill", 6'(a), pat(a, 1), 1'b0, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) cyc("R6 R4 read", 6'(a), 18'h3FFFF, 1'b1, 1'b1, 2'b00, SEL_ON, 1'b0, 1'b0);
    // R3: byte-write subsets, including the empty one
    for (int a = 0; a < DEPTH; a++) cyc("R3 R9 bytewr", 6'(a), pat(a, 2), 1'b1, 1'b0, 2'(a % 4), SEL_ON, 1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) cyc("R3 read", 6'(a), 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    // R2: global write overrides byte-write enable and disabled lanes
    cyc("R2 override", 6'd9, 18'h1ABCD, 1'b0, 1'b0, 2'b11, SEL_ON, 1'b0, 1'b0);
    // R5: back-to-back write then read of the same word
    cyc("R5 read", 6'd9, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    cyc("R5 write", 6'd10, 18'h2468A, 1'b0, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    cyc("R5 read", 6'd10, 18'h11111, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    // R7: every non-selecting chip-select pattern tries a write, then a read
    for (int s = 0; s < 8; s++) begin
      if (3'(s) != SEL_ON) begin
        cyc("R7 write", 6'd5, 18'h15555 ^ 18'(s), 1'b0, 1'b1, 2'b00, 3'(s), 1'b0, 1'b0);
        cyc("R7 read", 6'd5, 18'd0, 1'b1, 1'b1, 2'b11, 3'(s), 1'b0, 1'b0);
        cyc("R7 verify", 6'd5, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
      end
    end
    // R8: oeN high blocks the drive; lowering it without a clock drives at once
    cyc("R8 oe off", 6'd7, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b1);
    #1 oeN = 1'b0;
    #1;
    check("R8 async drive", {17'd0, driveEn}, 18'd1);
    check("R8 async data", dataOut, model[7]);
    // R1: address change between edges leaves the output alone
    cyc("R1 read", 6'd12, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    addr = 6'd13;
    gwN = 1'b0;
    #1;
    check("R1 hold data", dataOut, model[12]);
    check("R1 hold drive", {17'd0, driveEn}, 18'd1);
    // R10: snooze blocks writes and reads; contents kept
    cyc("R10 write", 6'd20, 18'h0F0F0, 1'b0, 1'b1, 2'b00, SEL_ON, 1'b1, 1'b0);
    cyc("R10 read", 6'd20, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b1, 1'b0);
    cyc("R10 after", 6'd20, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    cyc("R10 other", 6'd21, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    // R9: write cycle with byte-write enable and no lane, output stays off
    cyc("R9 empty write", 6'd22, 18'h3FFFF, 1'b1, 1'b0, 2'b11, SEL_ON, 1'b0, 1'b0);
    cyc("R9 verify", 6'd22, 18'd0, 1'b1, 1'b1, 2'b11, SEL_ON, 1'b0, 1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule